// File: doc/BRIEF.md
# Shift-Register Fan-Out Stream Interleaver

This block takes one bit from every LED strip at a time and turns that set into a stream of parallel words. Each data line of the word drives an external eight-stage serial-in, parallel-out register that has its own storage latch, so one line feeds eight strips. For every source bit period the block sends a group of eight words, one per register stage. It also drives the storage latch through the lowest bit of the word. The words leave at eight times the per-strip bit rate, so every external register is refilled once per source bit.

Strip bits arrive on a valid/ready handshake, one complete set per transfer. Strip `s` is served by data line `s / 8` and appears on register output `s % 8`. A one-entry holding buffer lets the next set arrive while the current group is being sent, so sets that arrive back to back give groups with no gap between them. When no set is waiting, the block sends all-zero words and does not pulse the latch. A `shift_en` pulse marks each new word for the external shift clock. A `frame_start` pulse marks the first word of each group.

Top module: `srfan_interleaver`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state. After that edge `word_out` is 0, `shift_en` is 0, `frame_start` is 0 and `in_ready` is 1.
- R2: Word bit 0 is the latch. It is 1 only in the first word (slot 0) of each group. `frame_start` pulses together with the `shift_en` of that first word.
- R3: Each accepted set produces exactly eight active words. Consecutive `shift_en` pulses within a group are exactly `WORD_PERIOD` cycles apart.
- R4: In slot k (0 to 7) of a group, word bit L+1 carries strip bit `L*8 + (7-k)` of that group's set, so register stage 7 is sent first.
- R5: Model each data line as a register that shifts on `shift_en`, with the new bit entering stage 0, and that latches its contents when a word has bit 0 set. The latch pulse at the start of a group then shows strip `L*8+j` of the previous set on stage j of line L.
- R6: Word bits above bit `LINES` are always 0.
- R7: When no set is waiting at the end of a group, the words that follow are 0, the latch stays low, `shift_en` stays low and `in_ready` is 1.
- R8: A set is accepted only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low on the cycle after an accept. A set that is held valid while `in_ready` is low is not lost. Sets that arrive back to back give groups that start exactly `8*WORD_PERIOD` cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A strip bit set is offered on `in_bits` |
| in_ready | output | 1 | The holding buffer is free to accept a set |
| in_bits | input | LINES*8 | One bit per strip; strip `s` sits at bit `s` |
| word_out | output | WORD_W | Parallel word: bit 0 is the latch, bits 1..LINES are the data lines, the bits above are zero |
| shift_en | output | 1 | One-cycle pulse on the first cycle of each active word |
| frame_start | output | 1 | One-cycle pulse on the first word of each group |

## Verification
An accepted set affects the outputs through two register stages. The sequencer updates its slot state on a word tick. One cycle later the word, `shift_en` and `frame_start` are registered together, so the bench reads `word_out` only on negative edges where `shift_en` is high. At those samples it compares the word with the value the requirements give for that group and slot, and measures pulse spacing in cycles from the previous pulse. The result of the latch (R5) comes from a behavioural model of the external registers and appears one group later, so a final flush set is sent and latched contents are compared after the stream has drained. `in_ready` changes only at a clock edge. The bench therefore checks it on the negative edge right after an accept.

// File: rtl/srfan_pkg.sv
// Package: shared constants for the shift-register fan-out interleaver.
// Assumes external registers with exactly eight stages.
package srfan_pkg;
    localparam int SR_STAGES = 8;
    localparam int SLOT_W    = 3;
    typedef logic [SLOT_W-1:0] slot_t;
    localparam slot_t LAST_SLOT = slot_t'(SR_STAGES - 1);
endpackage

// File: rtl/srfan_word_timer.sv
// Module: srfan_word_timer
// Produces a one-cycle tick every PERIOD clocks, which sets the output word rate.
// Assumes PERIOD >= 1. With PERIOD = 1 the tick is high on every cycle.
module srfan_word_timer #(
    parameter int PERIOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] TOP = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    // Count cycles within one word period and wrap at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == TOP) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == TOP);

    generate
        if (PERIOD > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);  // R3
        end
    endgenerate
endmodule

// File: rtl/srfan_group_seq.sv
// Module: srfan_group_seq
// Accepts strip bit sets into a one-entry holding buffer and steps an
// eight-slot group over the current set once per word tick.
// Assumes that tick marks a word boundary. A new group starts only at
// a tick after slot 7, or at a tick while idle.
module srfan_group_seq
    import srfan_pkg::*;
#(
    parameter int NSTRIP = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_valid,
    input  logic [NSTRIP-1:0] in_bits,
    output logic              in_ready,
    output logic              active,
    output slot_t             slot,
    output logic [NSTRIP-1:0] cur_bits,
    output logic              word_start
);
    logic              pend_full;
    logic [NSTRIP-1:0] pend_bits;
    logic              accept;

    assign in_ready = !pend_full;
    assign accept   = in_valid && !pend_full;

    // Hold one set waiting and step the group state on each word tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_full  <= 1'b0;
            pend_bits  <= '0;
            cur_bits   <= '0;
            active     <= 1'b0;
            slot       <= '0;
            word_start <= 1'b0;
        end else begin
            word_start <= 1'b0;
            if (accept) begin
                pend_bits <= in_bits;
                pend_full <= 1'b1;
            end
            if (tick) begin
                if (active && slot != LAST_SLOT) begin
                    slot       <= slot + 1'b1;
                    word_start <= 1'b1;
                end else if (pend_full) begin
                    cur_bits   <= pend_bits;
                    slot       <= '0;
                    active     <= 1'b1;
                    pend_full  <= 1'b0;
                    word_start <= 1'b1;
                end else begin
                    active <= 1'b0;
                    slot   <= '0;
                end
            end
        end
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && active && slot != LAST_SLOT |=> active && slot == $past(slot) + 1'b1);  // R3
    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);  // R8
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready && !tick |=> !in_ready);  // R8
endmodule

// File: rtl/srfan_word_mux.sv
// Module: srfan_word_mux
// Registers the parallel word for the current slot. Bit 0 is the latch,
// bit L+1 carries stage (7 - slot) of data line L, and any bits above are zero.
// Assumes that slot and active are stable for a whole word period.
module srfan_word_mux
    import srfan_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int LINES  = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  slot_t                      slot,
    input  logic [LINES*SR_STAGES-1:0] cur_bits,
    input  logic                       word_start,
    output logic [WORD_W-1:0]          word_out,
    output logic                       shift_en,
    output logic                       frame_start
);
    logic [WORD_W-1:0] nxt_word;
    slot_t             stage_sel;

    assign stage_sel = LAST_SLOT - slot;

    generate
        for (genvar ln = 0; ln < LINES; ln++) begin : g_line
            logic [SR_STAGES-1:0] grp;
            assign grp             = cur_bits[ln*SR_STAGES +: SR_STAGES];
            assign nxt_word[ln+1]  = active && grp[stage_sel];
        end
        if (LINES < WORD_W - 1) begin : g_pad
            assign nxt_word[WORD_W-1:LINES+1] = '0;
        end
    endgenerate

    assign nxt_word[0] = active && (slot == '0);

    // Register the word and its strobes so that they change on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out    <= '0;
            shift_en    <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            word_out    <= nxt_word;
            shift_en    <= word_start;
            frame_start <= word_start && active && (slot == '0);
        end
    end

    AST_FRAME_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> word_out[0] && shift_en);  // R2
    AST_LATCH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_out[0]) |-> frame_start);  // R2
endmodule

// File: rtl/srfan_interleaver.sv
// Module: srfan_interleaver (top)
// Merges per-strip bit sets into groups of eight parallel words, one word per
// external register stage, with the storage latch in word bit 0.
// Assumes LINES <= WORD_W - 1 and WORD_PERIOD >= 1.
module srfan_interleaver
    import srfan_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int LINES       = WORD_W - 1,
    parameter int WORD_PERIOD = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [LINES*SR_STAGES-1:0] in_bits,
    output logic [WORD_W-1:0]          word_out,
    output logic                       shift_en,
    output logic                       frame_start
);
    localparam int NSTRIP = LINES * SR_STAGES;

    logic              tick;
    logic              active;
    slot_t             slot;
    logic [NSTRIP-1:0] cur_bits;
    logic              word_start;

    srfan_word_timer #(.PERIOD(WORD_PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    srfan_group_seq #(.NSTRIP(NSTRIP)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .in_valid   (in_valid),
        .in_bits    (in_bits),
        .in_ready   (in_ready),
        .active     (active),
        .slot       (slot),
        .cur_bits   (cur_bits),
        .word_start (word_start)
    );

    srfan_word_mux #(.WORD_W(WORD_W), .LINES(LINES)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .slot        (slot),
        .cur_bits    (cur_bits),
        .word_start  (word_start),
        .word_out    (word_out),
        .shift_en    (shift_en),
        .frame_start (frame_start)
    );

    generate
        if (LINES < WORD_W - 1) begin : g_pad_chk
            AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                word_out[WORD_W-1:LINES+1] == '0);  // R6
        end
    endgenerate

    AST_IDLE_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |-> !frame_start);  // R7
endmodule

// File: tb/srfan_interleaver_bench.sv
module srfan_interleaver_bench;
    localparam int W      = 8;
    localparam int LN     = 6;
    localparam int PER    = 2;
    localparam int NS     = LN * 8;
    localparam int NSTIM  = 6;   // last entry is the flush set

    localparam logic [NS-1:0] STIM [0:NSTIM-1] = '{
        48'hFFFF_FFFF_FFFF,
        48'hAAAA_5555_AAAA,
        48'h1234_5678_9ABC,
        48'h8000_0000_0001,
        48'h0F0F_F0F0_3C3C,
        48'h0000_0000_0000
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [NS-1:0] in_bits = '0;
    logic [W-1:0]  word_out;
    logic          shift_en;
    logic          frame_start;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // model state
    bit            mon_en = 1'b0;
    bit            streaming = 1'b0;
    int            wslot = 0;
    int            grp = 0;
    int            ncap = 0;
    int            nshift = 0;
    int            last_shift = 0;
    int            last_frame = 0;
    logic [7:0]    sr [LN];
    logic [NS-1:0] cap [8];

    srfan_interleaver #(.WORD_W(W), .LINES(LN), .WORD_PERIOD(PER)) u_srfan_interleaver (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bits(in_bits), .word_out(word_out), .shift_en(shift_en),
        .frame_start(frame_start)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic push(input logic [NS-1:0] v);
        in_valid = 1'b1;
        in_bits  = v;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R8 ready low after accept", in_ready, 0);
    endtask

    always @(negedge clk) cyc++;

    // behavioural model of the external registers, plus per-word checks
    always @(negedge clk) begin
        if (mon_en && shift_en) begin
            if (frame_start) begin
                if (grp > 0) check(wslot == 8, "R3 eight words per group", wslot, 8);
                if (grp > 0 && streaming)
                    check(cyc - last_frame == 8 * PER, "R8 back-to-back group spacing",
                          cyc - last_frame, 8 * PER);
                last_frame = cyc;
                wslot = 0;
                grp++;
            end else begin
                check(cyc - last_shift == PER, "R3 shift spacing", cyc - last_shift, PER);
            end
            check(word_out[0] == (wslot == 0), "R2 latch only in slot 0", word_out[0], wslot == 0);
            check(word_out[W-1:LN+1] == '0, "R6 unused bits zero", word_out, 0);
            if (grp >= 1 && grp <= NSTIM) begin
                logic [W-1:0] exp_w;
                exp_w = '0;
                exp_w[0] = (wslot == 0);
                for (int l = 0; l < LN; l++) exp_w[l+1] = STIM[grp-1][l*8 + 7 - wslot];
                check(word_out == exp_w, "R4 slot word contents", word_out, exp_w);
            end
            if (word_out[0] && ncap < 8) begin
                for (int l = 0; l < LN; l++) cap[ncap][l*8 +: 8] = sr[l];
                ncap++;
            end
            for (int l = 0; l < LN; l++) sr[l] = {sr[l][6:0], word_out[l+1]};
            wslot++;
            nshift++;
            last_shift = cyc;
        end
    end

    initial begin
        for (int l = 0; l < LN; l++) sr[l] = 8'h00;
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        report();
    end

    initial begin
        int n0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(word_out == '0 && !shift_en && !frame_start, "R1 outputs after reset",
              {word_out, shift_en, frame_start}, 0);
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        rst_n = 1'b1;
        // R7: no input -> nothing shifted
        repeat (10) @(negedge clk);
        check(!shift_en && word_out == '0, "R7 idle before input", word_out, 0);

        // table walk: stream every set back to back
        mon_en = 1'b1;
        for (int i = 0; i < NSTIM; i++) begin
            if (i == 1) streaming = 1'b1;
            push(STIM[i]);
        end
        repeat (20 * PER) @(negedge clk);
        streaming = 1'b0;

        // R5: latched contents equal the previous set
        check(ncap == NSTIM, "R5 latch count", ncap, NSTIM);
        check(cap[0] == '0, "R5 first latch holds cleared registers", cap[0], 0);
        for (int i = 1; i < NSTIM; i++)
            check(cap[i] == STIM[i-1], "R5 latched strips", cap[i], STIM[i-1]);
        check(grp == NSTIM, "R3 group count", grp, NSTIM);

        // R7: idle after drain
        n0 = nshift;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(!shift_en && word_out == '0 && !frame_start && in_ready,
                  "R7 idle after drain", {word_out, shift_en, in_ready}, 1);
        end
        check(nshift == n0, "R7 no shifts while idle", nshift, n0);

        // R1: reset in the middle of a group
        mon_en = 1'b0;
        push(48'h5A5A_5A5A_5A5A);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(word_out == '0 && !shift_en && !frame_start && in_ready,
              "R1 mid-group reset", {word_out, shift_en, frame_start, in_ready}, 1);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        check(word_out == '0 && in_ready, "R1 no group resumes after reset", word_out, 0);
        report();
    end
endmodule